// File: doc/BRIEF.md
# Statically Scheduled Multithreaded Issue Engine

This block is a wide-issue datapath that holds no interlocks. A compiler fills a schedule memory ahead of time. Each word in that memory has one slot for each functional-unit instance. On every cycle of a run the block issues one whole word. For each valid slot it reads two operands from the register bank of the named thread and pushes the result into that unit's fixed-depth pipeline. When the result leaves the pipeline it is written back to the register file of the same thread. The block never checks dependencies, never stalls and never forwards. Results are correct only if the schedule interleaves threads so that every consumer issues after its producer's result has landed.

The unit mix and every latency are parameters. The default mix has three add/subtract slots, two multiply slots, two divide slots and one placeholder exponent slot, with depths 7, 5, 6 and 17. The arithmetic is integer, so every result can be predicted. Each thread bank accepts a limited number of writebacks per cycle. If the schedule exceeds that limit, the block raises an error flag for that cycle. A host loads the schedule and the register contents while the block is idle, pulses start, waits for done, and then reads the results back.

Top module: `vliw_issue_engine`

## Requirements
- R1: After reset, busy, done and sched_err are low and every register of every thread reads 0.
- R2: Slot s occupies word bits [s*14 +: 14]. From the LSB, the fields are rb[2:0], ra[5:3], rd[8:6], thread[11:9], op[12] and valid[13]. Slots 0-2 are add/subtract units, 3-4 are multiply units, 5-6 are divide units and 7 is the exponent unit.
- R3: An add/subtract slot writes a+b when op=0 and a-b when op=1, both modulo 2^16.
- R4: A multiply slot writes the low 16 bits of the 32-bit product a*b when op=0 and the high 16 bits when op=1.
- R5: A divide slot writes a/b when op=0 and a%b when op=1. When b=0 it writes 16'hFFFF for op=0 and a for op=1.
- R6: The exponent slot writes 1<<(a mod 16) when op=0 and b<<(a mod 16) when op=1.
- R7: A result lands exactly L clock edges after its issue edge, where L is 7, 5, 6 or 17 by unit type. A word issued on the same edge as a landing reads the old register value.
- R8: A slot whose valid bit is clear changes no register and causes no writeback.
- R9: A start pulse latches len. Word w issues on the (w+1)-th edge after the start edge. busy is high from the start edge until done rises.
- R10: done rises len+17 edges after the start edge, on the same edge as the last possible writeback, and busy falls on that edge. done then holds until the next start.
- R11: A thread bank commits at most 2 writebacks per edge, taken in ascending slot order. Any further writebacks on that edge are dropped, and sched_err is high during the cycle before that edge.
- R12: A host load (ld_we) writes one register only while busy is low. While busy is high it is ignored. rd_data shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts the schedule at address 0 |
| len | input | 5 | Number of schedule words to run |
| prog_we | input | 1 | Schedule memory write enable |
| prog_addr | input | 4 | Schedule memory write address |
| prog_data | input | 112 | Schedule word (8 slots of 14 bits) |
| ld_we | input | 1 | Host register write enable |
| ld_tid | input | 3 | Host write thread |
| ld_reg | input | 3 | Host write register |
| ld_data | input | 16 | Host write data |
| rd_tid | input | 3 | Read port thread |
| rd_reg | input | 3 | Read port register |
| rd_data | output | 16 | Read port data |
| busy | output | 1 | Run or drain in progress |
| done | output | 1 | Schedule issued and all pipelines drained |
| sched_err | output | 1 | Writeback port overflow on the coming edge |

## Verification
The block has no handshake, so a wrong internal state appears at the ports only as a wrong value in a register or as a timing error. The bench watches one register through the read port on every edge of each run and compares it with a cycle-accurate arithmetic model. A pipeline that is one stage too short or too long therefore shows up on the exact edge where the value changes early or late. It also corrupts the value that a later word reads in a read-after-write test. Errors in the write-port arbitration show up as sched_err on the wrong cycle or as the wrong slot being dropped. A drain counter that is off by one moves done by one edge, which the per-edge busy/done check detects.

// File: rtl/vliw_issue_engine.sv
module vliw_issue_engine #(
  parameter int NTHR   = 8,
  parameter int NREG   = 8,
  parameter int DW     = 16,
  parameter int DEPTH  = 16,
  parameter int NADD   = 3,
  parameter int NMUL   = 2,
  parameter int NDIV   = 2,
  parameter int NEXP   = 1,
  parameter int LADD   = 7,
  parameter int LMUL   = 5,
  parameter int LDIV   = 6,
  parameter int LEXP   = 17,
  parameter int WPORTS = 2,
  localparam int TW    = $clog2(NTHR),
  localparam int RW    = $clog2(NREG),
  localparam int AW    = $clog2(DEPTH),
  localparam int NSLOT = NADD + NMUL + NDIV + NEXP,
  localparam int SW    = 2 + TW + 3 * RW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [AW:0]           len,
  input  logic                  prog_we,
  input  logic [AW-1:0]         prog_addr,
  input  logic [NSLOT*SW-1:0]   prog_data,
  input  logic                  ld_we,
  input  logic [TW-1:0]         ld_tid,
  input  logic [RW-1:0]         ld_reg,
  input  logic [DW-1:0]         ld_data,
  input  logic [TW-1:0]         rd_tid,
  input  logic [RW-1:0]         rd_reg,
  output logic [DW-1:0]         rd_data,
  output logic                  busy,
  output logic                  done,
  output logic                  sched_err
);
  localparam int LM01 = (LADD > LMUL) ? LADD : LMUL;
  localparam int LM23 = (LDIV > LEXP) ? LDIV : LEXP;
  localparam int LMAX = (LM01 > LM23) ? LM01 : LM23;
  localparam int CW   = $clog2(LMAX + 1);

  logic [NSLOT*SW-1:0] mem [DEPTH];
  logic [DW-1:0]       rf [NTHR][NREG];
  logic                running, draining;
  logic [AW-1:0]       pc;
  logic [AW:0]         len_q;
  logic [CW-1:0]       dcnt;
  logic [NSLOT*SW-1:0] word;

  logic [NSLOT-1:0]           wb_v, commit;
  logic [NSLOT-1:0][TW-1:0]   wb_t;
  logic [NSLOT-1:0][RW-1:0]   wb_r;
  logic [NSLOT-1:0][DW-1:0]   wb_d;

  assign busy      = running | draining;
  assign word      = mem[pc];
  assign rd_data   = rf[rd_tid][rd_reg];
  assign sched_err = |(wb_v & ~commit);

  always_ff @(posedge clk)
    if (prog_we) mem[prog_addr] <= prog_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      draining <= 1'b0;
      pc       <= '0;
      len_q    <= '0;
      dcnt     <= '0;
      done     <= 1'b0;
    end else if (start) begin
      running  <= (len != '0);
      draining <= (len == '0);
      pc       <= '0;
      len_q    <= len;
      dcnt     <= CW'(1);
      done     <= 1'b0;
    end else if (running) begin
      if ({1'b0, pc} + 1'b1 == len_q) begin
        running  <= 1'b0;
        draining <= 1'b1;
        dcnt     <= CW'(1);
      end else begin
        pc <= pc + 1'b1;
      end
    end else if (draining) begin
      if (dcnt == CW'(LMAX)) begin
        draining <= 1'b0;
        done     <= 1'b1;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam int KIND = (s < NADD) ? 0 : (s < NADD + NMUL) ? 1 :
                          (s < NADD + NMUL + NDIV) ? 2 : 3;
    localparam int LAT  = (KIND == 0) ? LADD : (KIND == 1) ? LMUL :
                          (KIND == 2) ? LDIV : LEXP;

    logic [SW-1:0] sl;
    logic [TW-1:0] tid;
    logic [DW-1:0] a, b, res;
    logic          op, go;
    logic [LAT-1:0] v;
    logic [TW+RW+DW-1:0] pipe [LAT];

    assign sl  = word[s*SW +: SW];
    assign tid = sl[3*RW +: TW];
    assign op  = sl[SW-2];
    assign go  = running & sl[SW-1];
    assign a   = rf[tid][sl[RW +: RW]];
    assign b   = rf[tid][sl[0 +: RW]];

    if (KIND == 0) begin : g_add
      assign res = op ? a - b : a + b;
    end else if (KIND == 1) begin : g_mul
      logic [2*DW-1:0] prod;
      assign prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
      assign res  = op ? prod[2*DW-1:DW] : prod[DW-1:0];
    end else if (KIND == 2) begin : g_div
      assign res = (b == '0) ? (op ? a : '1) : (op ? a % b : a / b);
    end else begin : g_exp
      assign res = op ? (b << (a % DW)) : (DW'(1) << (a % DW));
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) v <= '0;
      else        v <= {v[LAT-2:0], go};

    always_ff @(posedge clk) begin
      pipe[0] <= {tid, sl[2*RW +: RW], res};
      for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end

    assign wb_v[s] = v[LAT-1];
    assign {wb_t[s], wb_r[s], wb_d[s]} = pipe[LAT-1];
  end

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      int n;
      n = 0;
      for (int q = 0; q < s; q++)
        if (wb_v[q] && wb_t[q] == wb_t[s]) n = n + 1;
      commit[s] = wb_v[s] && (n < WPORTS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++)
        for (int r = 0; r < NREG; r++)
          rf[t][r] <= '0;
    end else begin
      if (ld_we && !busy) rf[ld_tid][ld_reg] <= ld_data;
      for (int s = 0; s < NSLOT; s++)
        if (commit[s]) rf[wb_t[s]][wb_r[s]] <= wb_d[s];
    end
  end
endmodule

// File: rtl/vliw_issue_engine_chk.sv
module vliw_issue_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sched_err
);
  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R9
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done));

  // R11
  err_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sched_err |-> busy);

  // R10
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

bind vliw_issue_engine vliw_issue_engine_chk u_chk (.*);

// File: tb/vliw_issue_engine_test.sv
`timescale 1ns/1ps
module vliw_issue_engine_test;
  localparam int SW = 14;
  localparam int LM = 17;

  logic         clk = 0, rst_n = 0, start = 0;
  logic [4:0]   len = '0;
  logic         prog_we = 0;
  logic [3:0]   prog_addr = '0;
  logic [111:0] prog_data = '0;
  logic         ld_we = 0;
  logic [2:0]   ld_tid = '0, ld_reg = '0, rd_tid = '0, rd_reg = '0;
  logic [15:0]  ld_data = '0;
  logic [15:0]  rd_data;
  logic         busy, done, sched_err;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [15:0]  mreg [8][8];
  logic [111:0] prog [16];

  vliw_issue_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .ld_we(ld_we), .ld_tid(ld_tid), .ld_reg(ld_reg), .ld_data(ld_data),
    .rd_tid(rd_tid), .rd_reg(rd_reg), .rd_data(rd_data),
    .busy(busy), .done(done), .sched_err(sched_err));

  always #2 clk = ~clk;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lat(int s);
    if (s < 3) return 7;
    if (s < 5) return 5;
    if (s < 7) return 6;
    return 17;
  endfunction

  function automatic logic [15:0] calc(int s, bit op, logic [15:0] a, logic [15:0] b);
    logic [31:0] p;
    if (s < 3) return op ? 16'(a - b) : 16'(a + b);
    if (s < 5) begin
      p = 32'(a) * 32'(b);
      return op ? p[31:16] : p[15:0];
    end
    if (s < 7) begin
      if (b == 0) return op ? a : 16'hFFFF;
      return op ? a % b : a / b;
    end
    return op ? 16'(b << (a % 16)) : 16'(16'h1 << (a % 16));
  endfunction

  task automatic clr_prog();
    for (int w = 0; w < 16; w++) prog[w] = '0;
  endtask

  task automatic set_slot(int w, int s, bit v, bit op, int t, int rd, int ra, int rb);
    prog[w][s*SW +: SW] = {v, op, 3'(t), 3'(rd), 3'(ra), 3'(rb)};
  endtask

  task automatic run(int n, int wt, int wr, string tag);
    bit          pv [64][8];
    int          pt [64][8], pr [64][8];
    logic [15:0] pd [64][8];
    bit          perr [64];
    logic [15:0] hist [64];
    int last = n + LM;
    for (int e = 0; e < 64; e++) begin
      perr[e] = 0;
      for (int s = 0; s < 8; s++) pv[e][s] = 0;
    end
    for (int e = 1; e <= last; e++) begin
      if (e <= n)
        for (int s = 0; s < 8; s++) begin
          logic [13:0] sl = prog[e-1][s*SW +: SW];
          if (sl[13]) begin
            int t = int'(sl[11:9]);
            int le = e + lat(s);
            pv[le][s] = 1; pt[le][s] = t; pr[le][s] = int'(sl[8:6]);
            pd[le][s] = calc(s, sl[12], mreg[t][sl[5:3]], mreg[t][sl[2:0]]);
          end
        end
      for (int s = 0; s < 8; s++)
        if (pv[e][s]) begin
          int c = 0;
          for (int q = 0; q < s; q++) if (pv[e][q] && pt[e][q] == pt[e][s]) c++;
          if (c < 2) mreg[pt[e][s]][pr[e][s]] = pd[e][s];
          else perr[e] = 1;
        end
      hist[e] = mreg[wt][wr];
    end
    for (int w = 0; w < n; w++) begin
      @(posedge clk); #1;
      prog_we = 1; prog_addr = 4'(w); prog_data = prog[w];
    end
    @(posedge clk); #1;
    prog_we = 0; start = 1; len = 5'(n); rd_tid = 3'(wt); rd_reg = 3'(wr);
    @(posedge clk); #1;
    start = 0;
    chk(busy && !done, "R9", {tag, " busy after start"}, {busy, done}, 2'b10);
    for (int k = 1; k <= last; k++) begin
      @(posedge clk); #1;
      if (k == 2) begin
        ld_we = 1; ld_tid = 0; ld_reg = 0; ld_data = ~mreg[0][0];
      end
      if (k == 3) ld_we = 0;
      chk(rd_data === hist[k], "R7", {tag, " watched register per edge"}, rd_data, hist[k]);
      chk(sched_err === ((k + 1 <= last) ? perr[k+1] : 1'b0), "R11",
          {tag, " sched_err"}, sched_err, (k + 1 <= last) ? perr[k+1] : 1'b0);
      if (k < last)
        chk(busy && !done, "R10", {tag, " still running"}, {busy, done}, 2'b10);
      else
        chk(!busy && done, "R10", {tag, " done edge"}, {busy, done}, 2'b01);
    end
    for (int t = 0; t < 8; t++)
      for (int r = 0; r < 8; r++) begin
        rd_tid = 3'(t); rd_reg = 3'(r); #0.1;
        chk(rd_data === mreg[t][r], "R12", {tag, " final register"}, rd_data, mreg[t][r]);
      end
    @(posedge clk); #1;
    chk(done === 1'b1, "R10", {tag, " done held"}, done, 1);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk({busy, done, sched_err} === 3'b000, "R1", "status after reset", {busy, done, sched_err}, 0);
    for (int t = 0; t < 8; t++)
      for (int r = 0; r < 8; r++) begin
        rd_tid = 3'(t); rd_reg = 3'(r); #0.1;
        chk(rd_data === 16'h0, "R1", "register after reset", rd_data, 0);
      end
    for (int t = 0; t < 8; t++)
      for (int r = 0; r < 8; r++) begin
        @(posedge clk); #1;
        mreg[t][r] = (t == 7 && r == 7) ? 16'h0 : 16'(t * 4099 + r * 771 + 5);
        ld_we = 1; ld_tid = 3'(t); ld_reg = 3'(r); ld_data = mreg[t][r];
      end
    @(posedge clk); #1;
    ld_we = 0;
    for (int t = 0; t < 8; t++) begin
      rd_tid = 3'(t); rd_reg = 3'(t); #0.1;
      chk(rd_data === mreg[t][t], "R12", "idle host load", rd_data, mreg[t][t]);
    end

    // R7 with R3 R4 R5 R6: one slot per unit type, exact landing edge
    foreach (prog[i]) prog[i] = '0;
    for (int i = 0; i < 4; i++) begin
      int s = (i == 0) ? 0 : (i == 1) ? 3 : (i == 2) ? 5 : 7;
      clr_prog();
      set_slot(0, s, 1, i[0], 2, 4, 1, 2);
      run(1, 2, 4, "R7 single slot");
    end

    // R2 R3 R4 R5 R6: full-width words sweeping ops, threads and operands
    for (int p = 0; p < 4; p++) begin
      clr_prog();
      for (int s = 0; s < 8; s++)
        set_slot(0, s, 1, (s + p) % 2, (s + p) % 8, (s + p + 5) % 8, p, (p == 2) ? 7 : (p + 3) % 8);
      run(1, (7 + p) % 8, (p + 4) % 8, "R2 sweep");
    end

    // R8 R11 and read-after-write timing across words
    clr_prog();
    set_slot(0, 0, 1, 0, 0, 5, 1, 2);
    set_slot(0, 1, 0, 1, 1, 1, 1, 1);
    set_slot(0, 2, 1, 1, 4, 1, 2, 3);
    set_slot(1, 5, 1, 0, 0, 6, 3, 1);
    set_slot(1, 6, 1, 1, 4, 2, 3, 4);
    set_slot(2, 3, 1, 0, 0, 7, 2, 3);
    set_slot(7, 1, 1, 0, 0, 3, 5, 5);
    set_slot(8, 2, 1, 1, 0, 4, 5, 0);
    for (int s = 0; s < 8; s++) set_slot(9, s, 0, 1, s, 0, 1, 2);
    run(10, 0, 5, "R8 R11 collision");

    // R9: restart after done with a two-word schedule
    clr_prog();
    set_slot(0, 4, 1, 1, 6, 0, 3, 4);
    set_slot(1, 7, 1, 1, 6, 1, 0, 2);
    run(2, 6, 1, "R9 restart");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule